// File: doc/BRIEF.md
# Range-Matching Translation Buffer

This block is a small, fully associative address translation buffer. Each slot holds a virtual base address, a region length, a physical frame address and a valid flag. A slot covers every virtual address from its base up to, but not including, base plus length. A requester presents a virtual address on the lookup port. All valid slots are compared in parallel, and one cycle later the block returns either a physical address or a fault flag that carries the virtual address that failed.

New mappings arrive on the insert port. An insert uses an empty slot when one exists. Only when every slot is valid does it evict the least recently used slot. Recency is kept as a rank per slot. A hit or an insert moves the touched slot to the front, and every slot that was more recent than it moves back by one place. A flush input empties the whole buffer in a single cycle.

Top module: `range_tlb`

## Requirements
- R1: A valid slot matches address A when its base is less than or equal to A and base + length, computed without wrap-around in 33 bits, is strictly greater than A.
- R2: On a hit, the physical address is the slot's frame address ORed with bits [11:0] of the lookup address.
- R3: On a miss, the response shows hit = 0, fault = 1, the lookup address on the fault address output, and a physical address of 0. On a hit, fault = 0 and the fault address output is 0.
- R4: The response valid output is 1 exactly in the cycle after a cycle with a lookup request.
- R5: A lookup hit makes the matched slot the most recently used, so a later eviction spares it.
- R6: An insert writes the lowest-index empty slot while any slot is empty, and evicts nothing in that case.
- R7: When all slots are valid, an insert replaces the least recently used slot, and the new slot becomes the most recently used.
- R8: A flush empties every slot in one cycle, so every lookup after it misses until new inserts arrive.
- R9: When several valid slots match, the lowest-index slot supplies the translation.
- R10: A lookup in the same cycle as an insert is answered from the contents held before that insert. The insert alone updates recency in that cycle. An insert in the same cycle as a flush is discarded.
- R11: After reset every slot is empty and the response valid output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request strobe |
| lookupAddr | input | 32 | Virtual address to translate |
| insertValid | input | 1 | Insert request strobe |
| insertBase | input | 32 | Virtual base of the new mapping |
| insertSize | input | 32 | Length in bytes of the new mapping |
| insertFrame | input | 32 | Physical frame address of the new mapping |
| flushAll | input | 1 | Empties every slot |
| respValid | output | 1 | Response present (one cycle after a lookup) |
| respHit | output | 1 | Lookup matched a slot |
| respFault | output | 1 | Lookup matched no slot |
| respPaddr | output | 32 | Translated physical address, 0 on a miss |
| respFaultAddr | output | 32 | Failing virtual address, 0 on a hit |

## Verification
The two functions that can fall in the same cycle are a lookup and an insert, and they can also coincide with a flush. The bench first provokes this directly. It inserts a range that covers an address that currently misses, and looks that address up in the same cycle. That response must be a miss, and the next lookup must hit. A flush paired with an insert must leave the inserted range unmapped. A long pseudo-random stream then mixes lookups, inserts and flushes in every combination. Each response is judged against a model kept in the bench, which applies the match, priority, fill and recency rules as the requirements state them.

// File: rtl/range_tlb_pkg.sv
package range_tlb_pkg;
  parameter int unsigned TLB_ENTRIES = 8;
  localparam int unsigned IDX_W = $clog2(TLB_ENTRIES);

  typedef struct packed {
    logic             clearAll;
    logic             writeEn;
    logic [IDX_W-1:0] writeIdx;
    logic             touchEn;
    logic [IDX_W-1:0] touchIdx;
  } tlbStrobes_t;
endpackage

// File: rtl/range_tlb_datapath.sv
module range_tlb_datapath
  import range_tlb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    lookupValid,
  input  logic [ADDR_W-1:0]       lookupAddr,
  input  logic [ADDR_W-1:0]       insertBase,
  input  logic [ADDR_W-1:0]       insertSize,
  input  logic [ADDR_W-1:0]       insertFrame,
  input  tlbStrobes_t             ctl,
  input  logic                    hitSel,
  input  logic [IDX_W-1:0]        hitIdx,
  output logic [TLB_ENTRIES-1:0]  matchVec,
  output logic [TLB_ENTRIES-1:0]  validVec,
  output logic [TLB_ENTRIES-1:0]  oldestVec,
  output logic                    respValid,
  output logic                    respHit,
  output logic                    respFault,
  output logic [ADDR_W-1:0]       respPaddr,
  output logic [ADDR_W-1:0]       respFaultAddr
);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'((64'd1 << OFS_W) - 64'd1);
  localparam logic [IDX_W-1:0]  LAST_RANK = IDX_W'(TLB_ENTRIES - 1);

  logic [ADDR_W-1:0] baseQ  [TLB_ENTRIES];
  logic [ADDR_W-1:0] sizeQ  [TLB_ENTRIES];
  logic [ADDR_W-1:0] frameQ [TLB_ENTRIES];
  logic [IDX_W-1:0]  rankQ  [TLB_ENTRIES];
  logic [TLB_ENTRIES-1:0] validQ;
  logic [TLB_ENTRIES-1:0] rankZeroVec;

  assign validVec = validQ;

  for (genvar g = 0; g < TLB_ENTRIES; g++) begin : gSlot
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);
    logic [ADDR_W:0] endAddr;

    assign endAddr      = {1'b0, baseQ[g]} + {1'b0, sizeQ[g]};
    assign matchVec[g]  = validQ[g] && (baseQ[g] <= lookupAddr) &&
                          (endAddr > {1'b0, lookupAddr});
    assign oldestVec[g] = (rankQ[g] == LAST_RANK);
    assign rankZeroVec[g] = (rankQ[g] == '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[g] <= 1'b0;
        baseQ[g]  <= '0;
        sizeQ[g]  <= '0;
        frameQ[g] <= '0;
      end else if (ctl.clearAll) begin
        validQ[g] <= 1'b0;
      end else if (ctl.writeEn && ctl.writeIdx == SLOT) begin
        validQ[g] <= 1'b1;
        baseQ[g]  <= insertBase;
        sizeQ[g]  <= insertSize;
        frameQ[g] <= insertFrame;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rankQ[g] <= SLOT;
      end else if (ctl.touchEn) begin
        if (ctl.touchIdx == SLOT)
          rankQ[g] <= '0;
        else if (rankQ[g] < rankQ[ctl.touchIdx])
          rankQ[g] <= rankQ[g] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid     <= 1'b0;
      respHit       <= 1'b0;
      respFault     <= 1'b0;
      respPaddr     <= '0;
      respFaultAddr <= '0;
    end else begin
      respValid     <= lookupValid;
      respHit       <= lookupValid && hitSel;
      respFault     <= lookupValid && !hitSel;
      respPaddr     <= (lookupValid && hitSel) ?
                       (frameQ[hitIdx] | (lookupAddr & OFS_MASK)) : '0;
      respFaultAddr <= (lookupValid && !hitSel) ? lookupAddr : '0;
    end
  end

  // R5, R7: exactly one slot holds the front rank at all times
  p_single_front_r5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(rankZeroVec) == 1);

  // R7: a touched slot is at the front in the following cycle
  p_touch_front_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.touchEn |=> rankZeroVec[$past(ctl.touchIdx)]);

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearAll |=> (validQ == '0));

  p_resp_timing_r4: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid);

  p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> (respPaddr == '0 && respFault));
endmodule

// File: rtl/range_tlb_control.sv
module range_tlb_control
  import range_tlb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lookupValid,
  input  logic                   insertValid,
  input  logic                   flushAll,
  input  logic [TLB_ENTRIES-1:0] matchVec,
  input  logic [TLB_ENTRIES-1:0] validVec,
  input  logic [TLB_ENTRIES-1:0] oldestVec,
  output tlbStrobes_t            ctl,
  output logic                   hitSel,
  output logic [IDX_W-1:0]       hitIdx
);
  logic [TLB_ENTRIES-1:0] freeVec;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] oldIdx;
  logic anyFree;
  logic victimIsFree;

  assign freeVec = ~validVec;
  assign anyFree = |freeVec;
  assign hitSel  = |matchVec;

  always_comb begin
    hitIdx  = '0;
    freeIdx = '0;
    oldIdx  = '0;
    for (int i = TLB_ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) hitIdx  = IDX_W'(i);
      if (freeVec[i])  freeIdx = IDX_W'(i);
      if (oldestVec[i]) oldIdx = IDX_W'(i);
    end
  end

  always_comb begin
    ctl.clearAll = flushAll;
    ctl.writeEn  = insertValid && !flushAll;
    ctl.writeIdx = anyFree ? freeIdx : oldIdx;
    ctl.touchEn  = ctl.writeEn || (lookupValid && hitSel && !flushAll && !insertValid);
    ctl.touchIdx = ctl.writeEn ? ctl.writeIdx : hitIdx;
  end

  assign victimIsFree = freeVec[ctl.writeIdx];

  p_fill_free_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.writeEn && anyFree) |-> victimIsFree);

  p_flush_drops_insert_r10: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |-> (!ctl.writeEn && !ctl.touchEn));

  p_evict_oldest_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.writeEn && !anyFree) |-> oldestVec[ctl.writeIdx]);
endmodule

// File: rtl/range_tlb.sv
module range_tlb
  import range_tlb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic              insertValid,
  input  logic [ADDR_W-1:0] insertBase,
  input  logic [ADDR_W-1:0] insertSize,
  input  logic [ADDR_W-1:0] insertFrame,
  input  logic              flushAll,
  output logic              respValid,
  output logic              respHit,
  output logic              respFault,
  output logic [ADDR_W-1:0] respPaddr,
  output logic [ADDR_W-1:0] respFaultAddr
);
  tlbStrobes_t ctl;
  logic hitSel;
  logic [IDX_W-1:0] hitIdx;
  logic [TLB_ENTRIES-1:0] matchVec, validVec, oldestVec;

  range_tlb_control u_control (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .insertValid(insertValid), .flushAll(flushAll),
    .matchVec(matchVec), .validVec(validVec), .oldestVec(oldestVec),
    .ctl(ctl), .hitSel(hitSel), .hitIdx(hitIdx)
  );

  range_tlb_datapath #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_datapath (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .insertBase(insertBase), .insertSize(insertSize), .insertFrame(insertFrame),
    .ctl(ctl), .hitSel(hitSel), .hitIdx(hitIdx),
    .matchVec(matchVec), .validVec(validVec), .oldestVec(oldestVec),
    .respValid(respValid), .respHit(respHit), .respFault(respFault),
    .respPaddr(respPaddr), .respFaultAddr(respFaultAddr)
  );
endmodule

// File: tb/test_range_tlb.sv
module test_range_tlb;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0, insertValid = 1'b0, flushAll = 1'b0;
  logic [31:0] lookupAddr = '0, insertBase = '0, insertSize = '0, insertFrame = '0;
  logic respValid, respHit, respFault;
  logic [31:0] respPaddr, respFaultAddr;

  int checks = 0;
  int errors = 0;

  logic [31:0] mBase [N];
  logic [31:0] mSize [N];
  logic [31:0] mFrame[N];
  logic        mValid[N];
  int          mRank [N];

  always #10 clk = ~clk;

  range_tlb i_range_tlb (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .insertValid(insertValid), .insertBase(insertBase),
    .insertSize(insertSize), .insertFrame(insertFrame), .flushAll(flushAll),
    .respValid(respValid), .respHit(respHit), .respFault(respFault),
    .respPaddr(respPaddr), .respFaultAddr(respFaultAddr)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int modelMatch(input logic [31:0] a);
    int idx = -1;
    for (int i = N - 1; i >= 0; i--) begin
      logic [32:0] e;
      e = {1'b0, mBase[i]} + {1'b0, mSize[i]};
      if (mValid[i] && mBase[i] <= a && e > {1'b0, a}) idx = i;
    end
    return idx;
  endfunction

  function automatic void modelTouch(input int t);
    int r = mRank[t];
    for (int i = 0; i < N; i++) if (mRank[i] < r) mRank[i]++;
    mRank[t] = 0;
  endfunction

  function automatic void modelReset();
    for (int i = 0; i < N; i++) begin
      mValid[i] = 1'b0; mRank[i] = i;
      mBase[i] = '0; mSize[i] = '0; mFrame[i] = '0;
    end
  endfunction

  // one cycle of stimulus; response checked at the following falling edge
  task automatic step(input logic lv, input logic [31:0] la,
                      input logic iv, input logic [31:0] ib,
                      input logic [31:0] isz, input logic [31:0] ifr,
                      input logic fl, input string tag);
    int h;
    logic [31:0] ePaddr;
    h = modelMatch(la);
    ePaddr = (h >= 0) ? (mFrame[h] | (la & 32'h0000_0FFF)) : 32'h0;
    lookupValid = lv; lookupAddr = la;
    insertValid = iv; insertBase = ib; insertSize = isz; insertFrame = ifr;
    flushAll = fl;
    @(negedge clk);
    lookupValid = 1'b0; insertValid = 1'b0; flushAll = 1'b0;
    chk("R4", "respValid", {31'b0, respValid}, {31'b0, lv});
    if (lv) begin
      chk(tag, "respHit", {31'b0, respHit}, {31'b0, (h >= 0)});
      chk((h >= 0) ? "R2" : "R3", "respPaddr", respPaddr, ePaddr);
      chk("R3", "respFault", {31'b0, respFault}, {31'b0, (h < 0)});
      chk("R3", "respFaultAddr", respFaultAddr, (h < 0) ? la : 32'h0);
    end
    if (fl) begin
      for (int i = 0; i < N; i++) mValid[i] = 1'b0;
    end else if (iv) begin
      int v = -1;
      for (int i = N - 1; i >= 0; i--) if (!mValid[i]) v = i;
      if (v < 0) for (int i = 0; i < N; i++) if (mRank[i] == N - 1) v = i;
      mValid[v] = 1'b1; mBase[v] = ib; mSize[v] = isz; mFrame[v] = ifr;
      modelTouch(v);
    end else if (lv && h >= 0) begin
      modelTouch(h);
    end
  endtask

  task automatic look(input logic [31:0] a, input string tag);
    step(1'b1, a, 1'b0, '0, '0, '0, 1'b0, tag);
  endtask

  task automatic ins(input logic [31:0] b, input logic [31:0] s, input logic [31:0] f);
    step(1'b0, '0, 1'b1, b, s, f, 1'b0, "R6");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk("R11", "respValid after reset", {31'b0, respValid}, 32'h0);
    look(32'h1000_0000, "R11");

    // R6 / R1 / R2: fill every slot, then sweep range edges
    for (int i = 0; i < N; i++)
      ins(32'h1000_0000 + i * 32'h0010_0000, 32'h1000 << i, 32'h8000_0000 + i * 32'h0100_0000);
    for (int i = 0; i < N; i++) begin
      logic [31:0] b, z;
      b = 32'h1000_0000 + i * 32'h0010_0000;
      z = 32'h1000 << i;
      look(b, "R1");
      look(b + z - 1, "R1");
      look(b + z, "R1");
      look(b - 1, "R1");
      look(b + 32'h0000_0ABC, "R2");
    end

    // R5: touch the oldest slot, then an eviction must spare it
    look(32'h1000_0000, "R5");
    ins(32'h5000_0000, 32'h1000, 32'h0123_4000);
    look(32'h1000_0000, "R5");
    look(32'h5000_0010, "R7");
    for (int i = 1; i < N; i++) look(32'h1000_0000 + i * 32'h0010_0000, "R7");

    // R1: range reaching the top of the address space
    ins(32'hFFFF_F000, 32'h0000_2000, 32'h00AB_C000);
    look(32'hFFFF_FFFF, "R1");

    // R8: flush empties everything
    step(1'b0, '0, 1'b0, '0, '0, '0, 1'b1, "R8");
    look(32'h5000_0010, "R8");
    look(32'hFFFF_FFFF, "R8");
    for (int i = 0; i < N; i++) look(32'h1000_0000 + i * 32'h0010_0000, "R8");

    // R9: overlapping ranges, lowest index wins
    ins(32'h2000_0000, 32'h0001_0000, 32'hA000_0000);
    ins(32'h2000_8000, 32'h0001_0000, 32'hB000_0000);
    look(32'h2000_9123, "R9");
    look(32'h2001_2345, "R9");

    // R10: lookup in the same cycle as an insert sees old contents
    step(1'b1, 32'h3000_0040, 1'b1, 32'h3000_0000, 32'h1000, 32'hC000_0000, 1'b0, "R10");
    look(32'h3000_0040, "R10");
    // R10: insert paired with flush is discarded
    step(1'b1, 32'h3000_0040, 1'b1, 32'h3100_0000, 32'h1000, 32'hD000_0000, 1'b1, "R10");
    look(32'h3100_0000, "R10");
    look(32'h3000_0040, "R10");

    // mixed stream against the model
    s = 32'h1234_5678;
    for (int k = 0; k < 4000; k++) begin
      logic lv, iv, fl;
      logic [31:0] la, ib, isz, ifr;
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      fl  = (s[4:0] == 5'd0);
      iv  = (s[6:5] == 2'd0);
      lv  = (s[7] | !iv);
      ib  = 32'h4000_0000 + {s[11:8], 13'h0};
      isz = {17'h0, s[14:12] + 3'd1, 12'h0};
      ifr = {s[31:20], 20'h0};
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      la  = 32'h3FFF_F000 + {15'h0, s[16:0]};
      step(lv, la, iv, ib, isz, ifr, fl, iv ? "R10" : "R1");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule